// File: doc/BRIEF.md
# Vector Prefix Undefined-Opcode Checker

This decode-stage checker examines the three payload bytes of a four-byte extended vector instruction prefix. It decides whether the instruction must take an undefined-opcode fault. Each decision is based on four inputs: the payload bits, whether the core is in 64-bit mode, a category code for the instruction, and the 8-bit mask of state components that the operating system has enabled. The checker returns a single fault decision with one cause code. It also returns the decoded vector length, the static rounding mode and a broadcast-enable flag.

The payload is presented as a 24-bit word. Bits [7:0] hold the first payload byte, bits [15:8] the second and bits [23:16] the third. So the broadcast/rounding bit is bit 20, and the length/rounding field is bits [22:21]. The result is held in one registered stage with a valid/ready handshake. The input stalls while a result is waiting and the consumer is not ready.

Top module: `vpfx_ud_check`

## Requirements
- R1: For a new-prefix category (codes 3..7), the fixed fields are tested: payload bits [3:2] nonzero, payload bit 10 clear, or map field [1:0] equal to 00. Any one of these gives cause 3 with fault high, whatever the mode.
- R2: For a new-prefix category outside 64-bit mode, payload bits [7:6] other than 11 mean the bytes are the legacy bounds-check instruction. The result is cause 1 with fault low and vector length, rounding mode and broadcast all zero. In 64-bit mode, bits [7:6] have no effect.
- R3: Each category requires a set of mask bits:
  - category 0 (legacy SIMD) requires 8'h03;
  - category 1 (older 256-bit vector encoding) requires 8'h07;
  - category 2 (opmask) requires 8'h23;
  - categories 3..7 require 8'hE7.
  Any required bit that is clear gives cause 2 with fault high.
- R4: Category 3 (register-register floating point with rounding) with bit 20 set selects a static rounding mode. The mode is bits [22:21] (00 nearest-even, 01 down, 10 up, 11 toward zero), and the vector length output is 10 (512-bit). No reserved-length fault is raised.
- R5: For any other new-prefix case, the vector length output equals bits [22:21] (00 128-bit, 01 256-bit, 10 512-bit) and the rounding mode output is 00. The value 11 gives cause 4 with fault high, and the length output then reads 11.
- R6: For category 5 (load-op with memory source), bit 20 drives the broadcast-enable output. For categories 6 and 7 (explicit load/store/broadcast/gather/scatter), bit 20 set gives cause 5 with fault high. For categories 3 and 4, broadcast-enable is 0.
- R7: When several conditions hold, the reported cause follows this priority: bounds alias (1), then state (2), then fixed field (3), then reserved length (4), then broadcast (5).
- R8: Fault is high exactly when the cause is 2 or more. Cause 0 means a legal instruction.
- R9: For categories 0..2, only the state test of R3 applies. The payload is ignored, and vector length, rounding mode and broadcast outputs are zero.
- R10: in_ready is low exactly when out_valid is high and out_ready is low. A stalled result holds all its outputs unchanged. An accepted input appears on the outputs one cycle later with out_valid high.
- R11: A synchronous reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Checker can take an input this cycle |
| payload | input | 24 | Prefix payload bytes, first byte in [7:0] |
| mode64 | input | 1 | Core is in 64-bit mode |
| category | input | 3 | Instruction category code |
| state_en | input | 8 | Enabled state-component mask |
| out_valid | output | 1 | Result registers hold a result |
| out_ready | input | 1 | Consumer takes the result |
| fault | output | 1 | Undefined-opcode fault required |
| cause | output | 3 | Fault or alias cause code |
| vlen | output | 2 | Decoded vector length |
| rmode | output | 2 | Static rounding mode |
| bcast_en | output | 1 | Broadcast enabled |

## Verification
The assertions check the handshake on every cycle: in_ready drops under stall, stalled results stay stable, and accepted inputs yield a valid result. They also check that fault agrees with the cause code, that a static rounding mode always comes with the 512-bit length, that broadcast never appears beside a broadcast fault, and that the cause stays in range. Two things are shown only by the bench's directed and random scenarios against its own reference function: which cause wins among overlapping conditions, and the exact mask each category demands. The bench scenarios also show that the bounds alias depends on the mode and that category-0..2 words ignore the payload.

// File: rtl/vpfx_ud_check.sv
module vpfx_ud_check #(
  parameter int PW = 24,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] payload,
  input  logic          mode64,
  input  logic [2:0]    category,
  input  logic [MW-1:0] state_en,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          fault,
  output logic [2:0]    cause,
  output logic [1:0]    vlen,
  output logic [1:0]    rmode,
  output logic          bcast_en
);
  localparam logic [MW-1:0] NEED_SIMD = MW'(8'h03);
  localparam logic [MW-1:0] NEED_YMM  = MW'(8'h07);
  localparam logic [MW-1:0] NEED_KREG = MW'(8'h23);
  localparam logic [MW-1:0] NEED_ZMM  = MW'(8'hE7);

  logic [MW-1:0] need;
  always_comb begin
    case (category)
      3'd0:    need = NEED_SIMD;
      3'd1:    need = NEED_YMM;
      3'd2:    need = NEED_KREG;
      default: need = NEED_ZMM;
    endcase
  end

  wire       is_pfx  = category >= 3'd3;
  wire       bnd     = is_pfx && !mode64 && (payload[7:6] != 2'b11);
  wire       st_bad  = (state_en & need) != need;
  wire       fld_bad = (|payload[3:2]) || !payload[10] || (payload[1:0] == 2'b00);
  wire       bbit    = payload[20];
  wire [1:0] ll      = payload[22:21];
  wire       rnd     = (category == 3'd3) && bbit;
  wire       len_bad = !rnd && (ll == 2'b11);
  wire       bc_bad  = (category >= 3'd6) && bbit;
  wire       live    = is_pfx && !bnd;

  logic [2:0] c_nxt;
  always_comb begin
    if (bnd)                   c_nxt = 3'd1;
    else if (st_bad)           c_nxt = 3'd2;
    else if (!is_pfx)          c_nxt = 3'd0;
    else if (fld_bad)          c_nxt = 3'd3;
    else if (len_bad)          c_nxt = 3'd4;
    else if (bc_bad)           c_nxt = 3'd5;
    else                       c_nxt = 3'd0;
  end

  assign in_ready = !out_valid || out_ready;
  wire take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (take) out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      cause    <= c_nxt;
      fault    <= c_nxt >= 3'd2;
      vlen     <= !live ? 2'b00 : (rnd ? 2'b10 : ll);
      rmode    <= (live && rnd) ? ll : 2'b00;
      bcast_en <= live && (category == 3'd5) && bbit;
    end
  end

  // R10
  stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(cause) && $stable(fault)
      && $stable(vlen) && $stable(rmode) && $stable(bcast_en)));
  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
  // R8
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (fault == (cause >= 3'd2)) && (cause <= 3'd5));
  // R4
  round_len_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && rmode != 2'b00) |-> (vlen == 2'b10));
  // R6
  bcast_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && bcast_en) |-> (cause != 3'd5) && (cause != 3'd1));
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/vpfx_ud_check_tb.sv
module vpfx_ud_check_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, in_valid, in_ready, mode64, out_valid, out_ready;
  logic        fault, bcast_en;
  logic [23:0] payload;
  logic [2:0]  category, cause;
  logic [7:0]  state_en;
  logic [1:0]  vlen, rmode;
  int checks = 0, errors = 0;

  vpfx_ud_check u_dut (.clk, .rst, .in_valid, .in_ready, .payload, .mode64,
    .category, .state_en, .out_valid, .out_ready, .fault, .cause, .vlen,
    .rmode, .bcast_en);

  function automatic logic [8:0] ref_model(logic [23:0] p, logic m64,
                                           logic [2:0] cat, logic [7:0] en);
    logic [7:0] req;
    logic [2:0] c;
    logic [1:0] vl, rm;
    logic bc, pf, al, rn;
    req = (cat == 0) ? 8'h03 : (cat == 1) ? 8'h07 : (cat == 2) ? 8'h23 : 8'hE7;
    pf = cat >= 3;
    al = pf && !m64 && p[7:6] != 2'b11;
    rn = cat == 3 && p[20];
    vl = 0; rm = 0; bc = 0; c = 0;
    if (al) c = 1;
    else if ((en & req) != req) c = 2;
    else if (pf) begin
      if (p[3:2] != 0 || !p[10] || p[1:0] == 0) c = 3;
      else if (!rn && p[22:21] == 2'b11) c = 4;
      else if (cat >= 6 && p[20]) c = 5;
    end
    if (pf && !al) begin
      vl = rn ? 2'b10 : p[22:21];
      rm = rn ? p[22:21] : 2'b00;
      bc = cat == 5 && p[20];
    end
    return {c >= 2, c, vl, rm, bc};
  endfunction

  task automatic check(string tag, logic [8:0] exp);
    logic [8:0] act;
    act = {fault, cause, vlen, rmode, bcast_en};
    checks++;
    if (!out_valid || act !== exp) begin
      errors++;
      $display("FAIL %s: valid=%0b got %h expected %h", tag, out_valid, act, exp);
    end
  endtask

  task automatic send(string tag, logic [23:0] p, logic m, logic [2:0] cat, logic [7:0] en);
    @(negedge clk);
    payload = p; mode64 = m; category = cat; state_en = en;
    in_valid = 1; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check(tag, ref_model(p, m, cat, en));
  endtask

  // good new-prefix word: map 01, [3:2]=0, bit10=1, [7:6]=11
  localparam logic [23:0] GOOD = 24'h0004C1;

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] ea;
    rst = 1; in_valid = 0; out_ready = 1; payload = 0; mode64 = 1;
    category = 0; state_en = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R11: out_valid %b expected 0", out_valid); end

    send("R1 clean", GOOD | 24'h200000, 1, 4, 8'hE7);
    send("R1 bits32", GOOD | 24'h4, 1, 4, 8'hFF);
    send("R1 bit10", GOOD & ~24'h400, 0, 6, 8'hFF);
    send("R1 map00", GOOD & ~24'h3, 1, 5, 8'hFF);
    send("R2 alias", GOOD & ~24'hC0, 0, 4, 8'h00);
    send("R2 64bit", GOOD & ~24'hC0, 1, 4, 8'hFF);
    send("R3 simd", 24'hFFFFFF, 0, 0, 8'h01);
    send("R3 kreg", 24'h0, 0, 2, 8'h23);
    send("R3 kreg miss", 24'h0, 0, 2, 8'h03);
    send("R3 zmm miss", GOOD, 1, 3, 8'hE3);
    send("R4 round rz", GOOD | 24'h700000, 1, 3, 8'hFF);
    send("R4 round rd", GOOD | 24'h300000, 1, 3, 8'hFF);
    send("R5 resv", GOOD | 24'h600000, 1, 4, 8'hFF);
    send("R5 256", GOOD | 24'h200000, 1, 7, 8'hFF);
    send("R6 bcast", GOOD | 24'h100000, 1, 5, 8'hFF);
    send("R6 badb", GOOD | 24'h100000, 1, 6, 8'hFF);
    send("R7 prio", (GOOD & ~24'h400) | 24'h700000, 1, 7, 8'h07);
    send("R9 ignore", 24'h000000, 0, 1, 8'h07);

    // R10 stall
    @(negedge clk);
    payload = GOOD | 24'h100000; mode64 = 1; category = 5; state_en = 8'hFF;
    in_valid = 1; out_ready = 0;
    ea = ref_model(payload, 1, 5, 8'hFF);
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b0) begin errors++; $display("FAIL R10: in_ready %b expected 0", in_ready); end
    payload = GOOD | 24'h600000; category = 4;
    repeat (2) @(negedge clk);
    check("R10 hold", ea);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R10 next", ref_model(GOOD | 24'h600000, 1, 4, 8'hFF));
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R10: out_valid %b expected 0", out_valid); end

    // R11 reset while holding
    in_valid = 1; out_ready = 0;
    @(negedge clk);
    in_valid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R11: out_valid %b expected 0", out_valid); end

    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [23:0] p;
      logic [7:0] en;
      p = $urandom;
      if ($urandom % 2) p = (p & ~24'h0004CF) | GOOD | ($urandom % 3);
      en = ($urandom % 2) ? 8'hFF : 8'($urandom);
      send("R7 random", p, 1'($urandom), 3'($urandom), en);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule